// File: doc/BRIEF.md
# Voltage and Temperature Alarm Latch

This block gathers alarm conditions from the supply monitors of a chip and turns them into one alarm line for a processor. Three rails each report an under-limit and an over-limit level. Two temperature flags report whether the die is above its upper limit or below its lower limit. The rail levels are sampled each cycle. Each temperature flag is turned into two events, one when the flag asserts and one when it deasserts.

Every event sets its own sticky bit in a status register. Software clears a bit by writing a 1 to it. A second register holds one enable bit per event. The alarm output is asserted while any status bit is set together with its enable bit. Latching into status does not depend on the enables, so software can poll conditions that it has chosen not to route to the alarm. The comparisons that produce the detector levels are made outside this block.

Top module: `env_alarm_latch`

## Requirements
- R1: After reset the status register, the enable register and `alarm` are all zero.
- R2: A high level on `rail_lo[i]` sets status bit 2·i, and a high level on `rail_hi[i]` sets status bit 2·i+1. Index 0 is the 1.05 V rail, 1 is the 1.8 V rail and 2 is the 2.5 V rail. The bit reads as set two clock edges after the level is applied.
- R3: A 0→1 change of `temp_over` sets status bit 6, and a 1→0 change sets status bit 7. Each bit reads as set two edges after the change.
- R4: A 0→1 change of `temp_under` sets status bit 8, and a 1→0 change sets status bit 9. Each bit reads as set two edges after the change.
- R5: A set status bit stays set after its event has gone away. Writing 0 to that bit, or writing 1 to other bits, does not clear it. Writing 1 to its position at register address 0 clears it at that edge.
- R6: If an event occurs in the same cycle as a write of 1 to its status bit, the bit stays set.
- R7: The enable register at address 1 reads back the 10 bits last written. On both registers, bits 31:10 read as zero. Addresses 2 and 3 read as zero.
- R8: Status bits latch whether or not their enable bit is set. While no status bit is enabled, `alarm` stays low.
- R9: `alarm` is the OR over all bits of status AND enable, registered once. It goes high one edge after an enabled bit is set, and low one edge after the last enabled bit is cleared or disabled.
- R10: A temperature flag held at a steady level produces no further events, so a cleared bit 6 to 9 stays clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rail_lo | input | 3 | Under-limit levels, index 0/1/2 = 1.05/1.8/2.5 V |
| rail_hi | input | 3 | Over-limit levels, same indexing |
| temp_over | input | 1 | Temperature above upper limit |
| temp_under | input | 1 | Temperature below lower limit |
| reg_addr | input | 2 | Word address: 0 status, 1 enable |
| reg_wr | input | 1 | Write strobe, acts at the clock edge |
| reg_wdata | input | 10 | Write data (status: 1 clears; enable: value) |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| alarm | output | 1 | Registered alarm to the processor |

## Verification
A status bit that fails to latch, or that is lost, shows on the status read two edges after the stimulus. If that bit is enabled, it also shows on `alarm` one edge later. An edge detector that fires on a level instead of a change re-sets bits 6 to 9 after they are cleared, and this shows on the next status read. A clear that wins over a simultaneous event shows as a zero on the read right after the write. A mask leak shows as `alarm` rising while the enables are zero.

// File: rtl/env_alarm_pkg.sv
package env_alarm_pkg;
  localparam int RAIL_CNT = 3;
  localparam int TEMP_CNT = 2;
  localparam int EVT_W    = 2 * RAIL_CNT + 2 * TEMP_CNT;
  localparam int TEMP_LSB = 2 * RAIL_CNT;

  // next status value: a new event takes priority over a clear
  function automatic logic [EVT_W-1:0] sticky_next(
    input logic [EVT_W-1:0] cur,
    input logic [EVT_W-1:0] clr,
    input logic [EVT_W-1:0] evt);
    return (cur & ~clr) | evt;
  endfunction

  function automatic logic alarm_any(
    input logic [EVT_W-1:0] stat,
    input logic [EVT_W-1:0] ena);
    return |(stat & ena);
  endfunction
endpackage

// File: rtl/env_edge_detect.sv
module env_edge_detect #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_in,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] lvl_q;
  logic [W-1:0] lvl_qq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      lvl_qq <= '0;
    end else begin
      lvl_q  <= lvl_in;
      lvl_qq <= lvl_q;
    end
  end

  for (genvar g = 0; g < W; g++) begin : g_edge
    assign rise[g] = lvl_q[g] & ~lvl_qq[g];
    assign fall[g] = ~lvl_q[g] & lvl_qq[g];
  end
endmodule

// File: rtl/env_status_w1c.sv
module env_status_w1c
  import env_alarm_pkg::*;
#(
  parameter int W = EVT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] clr,
  output logic [W-1:0] status_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr) | evt;
  end
endmodule

// File: rtl/env_alarm_out.sv
module env_alarm_out
  import env_alarm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] status,
  input  logic [EVT_W-1:0] enable,
  output logic             alarm_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alarm_q <= 1'b0;
    else        alarm_q <= alarm_any(status, enable);
  end
endmodule

// File: rtl/env_alarm_latch.sv
module env_alarm_latch
  import env_alarm_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 2,
  parameter int STAT_ADDR = 0,
  parameter int MASK_ADDR = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [RAIL_CNT-1:0] rail_lo,
  input  logic [RAIL_CNT-1:0] rail_hi,
  input  logic                temp_over,
  input  logic                temp_under,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic [EVT_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                alarm
);
  localparam logic [ADDR_W-1:0] STAT_SEL = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] MASK_SEL = ADDR_W'(MASK_ADDR);
  localparam int PAD_W = DATA_W - EVT_W;

  logic [RAIL_CNT-1:0] rail_lo_q, rail_hi_q;
  logic [TEMP_CNT-1:0] temp_rise, temp_fall;
  logic [EVT_W-1:0]    evt_vec, clr_vec, status_q, enable_q;
  logic                stat_wr, mask_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rail_lo_q <= '0;
      rail_hi_q <= '0;
    end else begin
      rail_lo_q <= rail_lo;
      rail_hi_q <= rail_hi;
    end
  end

  env_edge_detect #(.W(TEMP_CNT)) i_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_in ({temp_under, temp_over}),
    .rise   (temp_rise),
    .fall   (temp_fall)
  );

  for (genvar r = 0; r < RAIL_CNT; r++) begin : g_rail_evt
    assign evt_vec[2*r]   = rail_lo_q[r];
    assign evt_vec[2*r+1] = rail_hi_q[r];
  end
  for (genvar t = 0; t < TEMP_CNT; t++) begin : g_temp_evt
    assign evt_vec[TEMP_LSB+2*t]   = temp_rise[t];
    assign evt_vec[TEMP_LSB+2*t+1] = temp_fall[t];
  end

  assign stat_wr = reg_wr && (reg_addr == STAT_SEL);
  assign mask_wr = reg_wr && (reg_addr == MASK_SEL);
  assign clr_vec = stat_wr ? reg_wdata : '0;

  env_status_w1c #(.W(EVT_W)) i_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt_vec),
    .clr      (clr_vec),
    .status_q (status_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       enable_q <= '0;
    else if (mask_wr) enable_q <= reg_wdata;
  end

  env_alarm_out i_alarm (
    .clk     (clk),
    .rst_n   (rst_n),
    .status  (status_q),
    .enable  (enable_q),
    .alarm_q (alarm)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == STAT_SEL)      reg_rdata = {{PAD_W{1'b0}}, status_q};
    else if (reg_addr == MASK_SEL) reg_rdata = {{PAD_W{1'b0}}, enable_q};
  end
endmodule

// File: rtl/env_alarm_checker.sv
module env_alarm_checker
  import env_alarm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [EVT_W-1:0]  evt_vec,
  input logic [EVT_W-1:0]  clr_vec,
  input logic [EVT_W-1:0]  status_q,
  input logic [EVT_W-1:0]  enable_q,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              alarm
);
  // R9: alarm follows the masked status one edge later
  assert_alarm_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (alarm == $past(|(status_q & enable_q))));

  // R5: a bit set and not cleared remains set
  assert_sticky_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status_q) & ~$past(clr_vec)) & ~status_q) == '0));

  // R6: event wins over a simultaneous clear
  assert_evt_beats_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_vec & clr_vec) != '0) |=>
      ((status_q & $past(evt_vec & clr_vec)) == $past(evt_vec & clr_vec)));

  // R8: every event latches regardless of enables
  assert_latch_unmasked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vec != '0) |=> ((status_q & $past(evt_vec)) == $past(evt_vec)));

  // R3 / R4: rise and fall of one flag never coincide
  assert_edge_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_vec[TEMP_LSB] && evt_vec[TEMP_LSB+1]));
  assert_edge_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_vec[TEMP_LSB+2] && evt_vec[TEMP_LSB+3]));

  // R7: upper read bits are zero
  assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[DATA_W-1:EVT_W] == '0));
endmodule

bind env_alarm_latch env_alarm_checker #(.DATA_W(DATA_W)) i_env_alarm_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_vec   (evt_vec),
  .clr_vec   (clr_vec),
  .status_q  (status_q),
  .enable_q  (enable_q),
  .reg_rdata (reg_rdata),
  .alarm     (alarm)
);

// File: tb/test_env_alarm_latch.sv
module test_env_alarm_latch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  rail_lo = '0, rail_hi = '0;
  logic        temp_over = 1'b0, temp_under = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [9:0]  reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        alarm;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  env_alarm_latch i_env_alarm_latch (
    .clk(clk), .rst_n(rst_n), .rail_lo(rail_lo), .rail_hi(rail_hi),
    .temp_over(temp_over), .temp_under(temp_under), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .alarm(alarm));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [9:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    cyc(1);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(2'd0, d); check("R1 status", d, 0);
    rd(2'd1, d); check("R1 enable", d, 0);
    check("R1 alarm", {31'd0, alarm}, 0);
  endtask

  task automatic t_rails;
    logic [31:0] d;
    for (int i = 0; i < 3; i++) begin
      rail_lo[i] = 1'b1; cyc(1); rail_lo[i] = 1'b0; cyc(1);
      rd(2'd0, d); check("R2 rail low", d, 32'd1 << (2*i));
      wr(2'd0, 10'd1 << (2*i)); cyc(1);
      rd(2'd0, d); check("R5 clear low", d, 0);
      rail_hi[i] = 1'b1; cyc(1); rail_hi[i] = 1'b0; cyc(1);
      rd(2'd0, d); check("R2 rail high", d, 32'd2 << (2*i));
      wr(2'd0, 10'h3FF); cyc(1);
    end
  endtask

  task automatic t_hold;
    logic [31:0] d;
    rail_hi[2] = 1'b1; cyc(1); rail_hi[2] = 1'b0; cyc(5);
    rd(2'd0, d); check("R5 held", d, 32'h20);
    wr(2'd0, 10'h000); rd(2'd0, d); check("R5 write 0", d, 32'h20);
    wr(2'd0, 10'h1DF); rd(2'd0, d); check("R5 other bits", d, 32'h20);
    wr(2'd0, 10'h020); rd(2'd0, d); check("R5 own bit", d, 0);
  endtask

  task automatic t_temp(input bit under);
    logic [31:0] d;
    int b;
    b = under ? 8 : 6;
    if (under) temp_under = 1'b1; else temp_over = 1'b1;
    cyc(1);
    rd(2'd0, d); check(under ? "R4 rise early" : "R3 rise early", d, 0);
    cyc(1);
    rd(2'd0, d); check(under ? "R4 rise" : "R3 rise", d, 32'd1 << b);
    cyc(3); wr(2'd0, 10'h3FF); cyc(3);
    rd(2'd0, d); check("R10 steady high", d, 0);
    if (under) temp_under = 1'b0; else temp_over = 1'b0;
    cyc(2);
    rd(2'd0, d); check(under ? "R4 fall" : "R3 fall", d, 32'd2 << b);
    wr(2'd0, 10'h3FF); cyc(3);
    rd(2'd0, d); check("R10 steady low", d, 0);
  endtask

  task automatic t_enable_rw;
    logic [31:0] d;
    wr(2'd1, 10'h3FF); rd(2'd1, d); check("R7 enable all", d, 32'h3FF);
    wr(2'd1, 10'h155); rd(2'd1, d); check("R7 enable pattern", d, 32'h155);
    rd(2'd2, d); check("R7 addr 2", d, 0);
    rd(2'd3, d); check("R7 addr 3", d, 0);
    wr(2'd1, 10'h000);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    rail_hi[1] = 1'b1; cyc(1); rail_hi[1] = 1'b0; cyc(1);
    rd(2'd0, d); check("R8 latched unmasked", d, 32'h8);
    cyc(3); check("R8 alarm low", {31'd0, alarm}, 0);
    wr(2'd1, 10'h008); check("R9 alarm not yet", {31'd0, alarm}, 0);
    cyc(1); check("R9 alarm rises", {31'd0, alarm}, 1);
    wr(2'd0, 10'h008); check("R9 alarm still", {31'd0, alarm}, 1);
    cyc(1); check("R9 alarm falls", {31'd0, alarm}, 0);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    wr(2'd1, 10'h001);
    rail_lo[0] = 1'b1; cyc(1);
    check("R9 alarm edge1", {31'd0, alarm}, 0);
    cyc(1); check("R9 alarm edge2", {31'd0, alarm}, 0);
    cyc(1); check("R9 alarm edge3", {31'd0, alarm}, 1);
    wr(2'd0, 10'h001);
    rd(2'd0, d); check("R6 event beats clear", d, 32'h1);
    rail_lo[0] = 1'b0; cyc(2);
    wr(2'd0, 10'h001); rd(2'd0, d); check("R6 clear after release", d, 0);
    cyc(1); check("R9 alarm off", {31'd0, alarm}, 0);
    wr(2'd1, 10'h000);
  endtask

  initial begin
    cyc(2); rst_n = 1'b1; cyc(1);
    t_reset();
    t_rails();
    t_hold();
    t_temp(1'b0);
    t_temp(1'b1);
    t_enable_rw();
    t_mask();
    t_collide();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule